// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block runs the clock-control state machine of a processor core. It follows the core through six states: Run, Halt, Grant, Snoop, Sleep and Deep. From these states it drives the clock enables for the core and L2 domains. It also holds interrupt-type events that arrive while the core is stopped, and releases them as single service strobes once the core runs again. A free-running reference clock drives the whole block and times the PLL settle wait on the way out of Deep.

The state moves in these ways:
- A halt strobe moves Run to Halt. A wake event moves Halt back to Run.
- An active-low stop-clock request moves Run or Halt to Grant. Releasing the request returns to whichever of the two the machine came from.
- A snoop start seen in Halt or Grant enters Snoop. Snoop done returns to the state the snoop started from.
- An active-low sleep request is honoured only in Grant, where it moves to Sleep. Releasing it in Sleep returns to Grant.
- Losing the bus clock in Sleep moves to Deep. When the bus clock comes back and stays present for the settle interval, the machine returns to Sleep.

A core reset request restarts the core. It returns every state to Run except Grant, which it keeps. Any input activity seen while the core is in Sleep or Deep sets a sticky error flag.

Top module: `pwr_state_ctl`

## Requirements
- R1: After power-on reset (rst_n low) the state code is 1 (Run), both clock enables are 1, no service strobe is high and the error flag is 0. The state codes are Run=1, Halt=2, Grant=3, Snoop=4, Sleep=5, Deep=6.
- R2: In Run, a halt strobe gives Halt one cycle later. In Halt, any of binit, smi, init, nmi or intr gives Run one cycle later.
- R3: A flush request in Run or Halt produces svc_flush one cycle later and leaves the state unchanged. A flush request in any other state has no effect, now or later.
- R4: A low stop_req_n in Run or Halt gives Grant one cycle later. A high stop_req_n in Grant returns to Halt if Grant was entered from Halt, and to Run otherwise. In Grant, this release takes priority over snoop start and sleep.
- R5: Events that arrive in Run, Halt, Grant or Snoop are held. They are strobed only while the state is Run, and each one is strobed once however many times it arrived.
- R6: Held events are strobed one per cycle, starting the cycle after Run is entered, in the order binit, smi, init, nmi, intr.
- R7: A snoop start in Halt or Grant gives Snoop one cycle later. Snoop done then returns to the state the snoop started from.
- R8: A low sleep_req_n moves Grant to Sleep and has no effect in Run or Halt. A high sleep_req_n in Sleep returns to Grant.
- R9: A low bclk_ok in Sleep gives Deep. Deep returns to Sleep only after bclk_ok has been high for SETTLE_CYC consecutive cycles. A drop of bclk_ok restarts the wait.
- R10: A cpu_reset pulse produces a one-cycle core_init and clears the held events. It keeps Grant as Grant and moves every other state, including Sleep and Deep, to Run.
- R11: l2_clk_en is 0 exactly while the state is Deep. It returns to 1 once Sleep is re-entered.
- R12: With cfg_gate_en=1, core_clk_en is 0 in Grant, Sleep and Deep and 1 in every other state. With cfg_gate_en=0, core_clk_en is always 1.
- R13: A snoop start, snoop done, halt strobe, flush or event seen in Sleep or Deep sets illegal_err. The flag stays set until power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_gate_en | input | 1 | Strap that allows internal clocks to stop (normally 1) |
| cpu_reset | input | 1 | Core reset request |
| halt_stb | input | 1 | Halt instruction executed |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| bclk_ok | input | 1 | Bus clock present |
| snoop_start | input | 1 | Snoop begins |
| snoop_done | input | 1 | Snoop serviced |
| evt_binit | input | 1 | Bus init event |
| evt_smi | input | 1 | System management interrupt |
| evt_init | input | 1 | Init event |
| evt_nmi | input | 1 | Non-maskable interrupt |
| evt_intr | input | 1 | Maskable interrupt |
| evt_flush | input | 1 | Cache flush request |
| pstate_o | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| l2_clk_en | output | 1 | L2 clock enable |
| svc_binit | output | 1 | Bus init service strobe |
| svc_smi | output | 1 | SMI service strobe |
| svc_init | output | 1 | Init service strobe |
| svc_nmi | output | 1 | NMI service strobe |
| svc_intr | output | 1 | Interrupt service strobe |
| svc_flush | output | 1 | Flush service strobe |
| core_init | output | 1 | Core re-initialise pulse |
| illegal_err | output | 1 | Sticky illegal-activity flag |

## Verification
Two things can land in the same cycle. A held event can be released in the cycle that the same event arrives again, and a stop-clock release can coincide with a snoop start in Grant. The random phase toggles every input independently, so both collisions happen many times. A bench model decides each one: a new arrival outlives the clear, and the stop release outranks the snoop. A directed step also drives the stop release and the snoop start in one cycle, and expects the return to Halt.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [2:0] {
        PS_RUN   = 3'd1,
        PS_HALT  = 3'd2,
        PS_GRANT = 3'd3,
        PS_SNOOP = 3'd4,
        PS_SLEEP = 3'd5,
        PS_DEEP  = 3'd6
    } pstate_t;

    localparam int NUM_EVT  = 5;
    localparam int EV_BINIT = 0;
    localparam int EV_SMI   = 1;
    localparam int EV_INIT  = 2;
    localparam int EV_NMI   = 3;
    localparam int EV_INTR  = 4;
endpackage

// File: rtl/pwr_evt_latch.sv
module pwr_evt_latch #(
    parameter int NEV = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] arrive,
    input  logic           capture,
    input  logic           release_en,
    input  logic           clear,
    output logic [NEV-1:0] svc
);
    logic [NEV-1:0] pend;
    logic [NEV-1:0] pick;
    logic [NEV-1:0] taken;
    logic [NEV-1:0] pend_nxt;

    // lowest index pending wins
    assign pick  = pend & (~pend + NEV'(1));
    assign taken = release_en ? pick : '0;

    always_comb begin
        if (clear)
            pend_nxt = '0;
        else
            pend_nxt = (pend & ~taken) | (capture ? arrive : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            svc  <= '0;
        end else begin
            pend <= pend_nxt;
            svc  <= clear ? '0 : taken;
        end
    end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int SETTLE_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
    import pwr_pkg::*;
#(
    parameter int SETTLE_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_gate_en,
    input  logic       cpu_reset,
    input  logic       halt_stb,
    input  logic       stop_req_n,
    input  logic       sleep_req_n,
    input  logic       bclk_ok,
    input  logic       snoop_start,
    input  logic       snoop_done,
    input  logic       evt_binit,
    input  logic       evt_smi,
    input  logic       evt_init,
    input  logic       evt_nmi,
    input  logic       evt_intr,
    input  logic       evt_flush,
    output logic [2:0] pstate_o,
    output logic       core_clk_en,
    output logic       l2_clk_en,
    output logic       svc_binit,
    output logic       svc_smi,
    output logic       svc_init,
    output logic       svc_nmi,
    output logic       svc_intr,
    output logic       svc_flush,
    output logic       core_init,
    output logic       illegal_err
);
    pstate_t state, nxt;
    logic grant_from_halt, grant_from_halt_nxt;
    logic snoop_from_halt, snoop_from_halt_nxt;
    logic [NUM_EVT-1:0] arrive;
    logic [NUM_EVT-1:0] svc;
    logic wake, quiet, activity, settle_done, clk_stopped;
    logic flush_q, init_q, err_q;

    assign arrive[EV_BINIT] = evt_binit;
    assign arrive[EV_SMI]   = evt_smi;
    assign arrive[EV_INIT]  = evt_init;
    assign arrive[EV_NMI]   = evt_nmi;
    assign arrive[EV_INTR]  = evt_intr;

    assign wake     = |arrive;
    assign quiet    = (state == PS_SLEEP) || (state == PS_DEEP);
    assign activity = wake | evt_flush | snoop_start | snoop_done | halt_stb;

    pwr_evt_latch #(.NEV(NUM_EVT)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .arrive     (arrive),
        .capture    (!quiet),
        .release_en (state == PS_RUN),
        .clear      (cpu_reset),
        .svc        (svc)
    );

    pwr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state == PS_DEEP) && bclk_ok),
        .done  (settle_done)
    );

    // next state
    always_comb begin
        nxt                 = state;
        grant_from_halt_nxt = grant_from_halt;
        snoop_from_halt_nxt = snoop_from_halt;
        unique case (state)
            PS_RUN: begin
                if (cpu_reset)
                    nxt = PS_RUN;
                else if (!stop_req_n) begin
                    nxt = PS_GRANT;
                    grant_from_halt_nxt = 1'b0;
                end else if (halt_stb)
                    nxt = PS_HALT;
            end
            PS_HALT: begin
                if (cpu_reset)
                    nxt = PS_RUN;
                else if (!stop_req_n) begin
                    nxt = PS_GRANT;
                    grant_from_halt_nxt = 1'b1;
                end else if (snoop_start) begin
                    nxt = PS_SNOOP;
                    snoop_from_halt_nxt = 1'b1;
                end else if (wake)
                    nxt = PS_RUN;
            end
            PS_GRANT: begin
                if (cpu_reset)
                    nxt = PS_GRANT;
                else if (stop_req_n)
                    nxt = grant_from_halt ? PS_HALT : PS_RUN;
                else if (snoop_start) begin
                    nxt = PS_SNOOP;
                    snoop_from_halt_nxt = 1'b0;
                end else if (!sleep_req_n)
                    nxt = PS_SLEEP;
            end
            PS_SNOOP: begin
                if (cpu_reset)
                    nxt = PS_RUN;
                else if (snoop_done)
                    nxt = snoop_from_halt ? PS_HALT : PS_GRANT;
            end
            PS_SLEEP: begin
                if (cpu_reset)
                    nxt = PS_RUN;
                else if (!bclk_ok)
                    nxt = PS_DEEP;
                else if (sleep_req_n)
                    nxt = PS_GRANT;
            end
            PS_DEEP: begin
                if (cpu_reset)
                    nxt = PS_RUN;
                else if (settle_done)
                    nxt = PS_SLEEP;
            end
            default: nxt = PS_RUN;
        endcase
    end

    // state register and registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state           <= PS_RUN;
            grant_from_halt <= 1'b0;
            snoop_from_halt <= 1'b0;
            flush_q         <= 1'b0;
            init_q          <= 1'b0;
            err_q           <= 1'b0;
        end else begin
            state           <= nxt;
            grant_from_halt <= grant_from_halt_nxt;
            snoop_from_halt <= snoop_from_halt_nxt;
            flush_q         <= evt_flush && ((state == PS_RUN) || (state == PS_HALT));
            init_q          <= cpu_reset;
            err_q           <= err_q | (quiet & activity);
        end
    end

    // outputs
    always_comb begin
        clk_stopped = (state == PS_GRANT) || (state == PS_SLEEP) || (state == PS_DEEP);
        pstate_o    = state;
        l2_clk_en   = (state != PS_DEEP);
        core_clk_en = !(clk_stopped && cfg_gate_en);
        svc_binit   = svc[EV_BINIT];
        svc_smi     = svc[EV_SMI];
        svc_init    = svc[EV_INIT];
        svc_nmi     = svc[EV_NMI];
        svc_intr    = svc[EV_INTR];
        svc_flush   = flush_q;
        core_init   = init_q;
        illegal_err = err_q;
    end
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
    import pwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_reset,
    input logic       bclk_ok,
    input logic [2:0] pstate_o,
    input logic       l2_clk_en,
    input logic       svc_binit,
    input logic       svc_smi,
    input logic       svc_init,
    input logic       svc_nmi,
    input logic       svc_intr,
    input logic       illegal_err
);
    logic past_ok;
    logic [4:0] svc_all;
    assign svc_all = {svc_intr, svc_nmi, svc_init, svc_smi, svc_binit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (pstate_o == PS_SLEEP && $past(pstate_o) != PS_SLEEP)
            |-> ($past(pstate_o) == PS_GRANT || $past(pstate_o) == PS_DEEP));

    assert_deep_exit_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(pstate_o) == PS_DEEP && pstate_o == PS_SLEEP) |-> $past(bclk_ok));

    assert_snoop_return_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(pstate_o) == PS_SNOOP && pstate_o != PS_SNOOP && !$past(cpu_reset))
            |-> (pstate_o == PS_HALT || pstate_o == PS_GRANT));

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $onehot0(svc_all));

    assert_strobe_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (|svc_all) |-> $past(pstate_o) == PS_RUN);

    assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        illegal_err |=> illegal_err);

    assert_grant_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(pstate_o) == PS_GRANT && $past(cpu_reset)) |-> pstate_o == PS_GRANT);

    assert_l2_restore_R11: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $rose(l2_clk_en) |-> (pstate_o == PS_SLEEP || pstate_o == PS_RUN));
endmodule

bind pwr_state_ctl pwr_state_chk u_pwr_state_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_reset   (cpu_reset),
    .bclk_ok     (bclk_ok),
    .pstate_o    (pstate_o),
    .l2_clk_en   (l2_clk_en),
    .svc_binit   (svc_binit),
    .svc_smi     (svc_smi),
    .svc_init    (svc_init),
    .svc_nmi     (svc_nmi),
    .svc_intr    (svc_intr),
    .illegal_err (illegal_err)
);

// File: tb/test_pwr_state_ctl.sv
module test_pwr_state_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 12;
    localparam int N_RAND     = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_gate_en = 1'b1, cpu_reset = 1'b0, halt_stb = 1'b0;
    logic stop_req_n = 1'b1, sleep_req_n = 1'b1, bclk_ok = 1'b1;
    logic snoop_start = 1'b0, snoop_done = 1'b0;
    logic evt_binit = 1'b0, evt_smi = 1'b0, evt_init = 1'b0, evt_nmi = 1'b0;
    logic evt_intr = 1'b0, evt_flush = 1'b0;
    logic [2:0] pstate_o;
    logic core_clk_en, l2_clk_en, svc_binit, svc_smi, svc_init, svc_nmi, svc_intr;
    logic svc_flush, core_init, illegal_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_ctl #(.SETTLE_CYC(SETTLE)) i_pwr_state_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_gate_en(cfg_gate_en), .cpu_reset(cpu_reset),
        .halt_stb(halt_stb), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
        .bclk_ok(bclk_ok), .snoop_start(snoop_start), .snoop_done(snoop_done),
        .evt_binit(evt_binit), .evt_smi(evt_smi), .evt_init(evt_init),
        .evt_nmi(evt_nmi), .evt_intr(evt_intr), .evt_flush(evt_flush),
        .pstate_o(pstate_o), .core_clk_en(core_clk_en), .l2_clk_en(l2_clk_en),
        .svc_binit(svc_binit), .svc_smi(svc_smi), .svc_init(svc_init),
        .svc_nmi(svc_nmi), .svc_intr(svc_intr), .svc_flush(svc_flush),
        .core_init(core_init), .illegal_err(illegal_err)
    );

    function automatic logic [4:0] svc_vec();
        return {svc_intr, svc_nmi, svc_init, svc_smi, svc_binit};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic por();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    // ---------------- bench model (random phase) ----------------
    bit rand_on = 1'b0;
    int m_st, m_cnt;
    bit m_gh, m_sh, m_flush, m_err;
    logic [4:0] m_pend, m_svc;

    function automatic int exp_next(input int st, input bit gh, input bit sh,
                                    input bit wake, input bit done);
        if (cpu_reset) return (st == 3) ? 3 : 1;
        case (st)
            1: if (!stop_req_n) return 3; else if (halt_stb) return 2; else return 1;
            2: if (!stop_req_n) return 3; else if (snoop_start) return 4;
               else if (wake) return 1; else return 2;
            3: if (stop_req_n) return gh ? 2 : 1; else if (snoop_start) return 4;
               else if (!sleep_req_n) return 5; else return 3;
            4: if (snoop_done) return sh ? 2 : 3; else return 4;
            5: if (!bclk_ok) return 6; else if (sleep_req_n) return 3; else return 5;
            6: if (done) return 5; else return 6;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rand_on) begin
            logic [4:0] arr, pick, taken;
            bit quiet, run, done, wake, act;
            int nst;
            arr   = {evt_intr, evt_nmi, evt_init, evt_smi, evt_binit};
            wake  = |arr;
            quiet = (m_st == 5) || (m_st == 6);
            pick  = m_pend & (~m_pend + 5'd1);
            taken = (m_st == 1) ? pick : 5'd0;
            run   = (m_st == 6) && bclk_ok;
            done  = run && (m_cnt == SETTLE - 1);
            act   = wake | evt_flush | snoop_start | snoop_done | halt_stb;
            nst   = exp_next(m_st, m_gh, m_sh, wake, done);
            if (!cpu_reset && m_st == 1 && !stop_req_n) m_gh = 1'b0;
            if (!cpu_reset && m_st == 2 && !stop_req_n) m_gh = 1'b1;
            if (!cpu_reset && nst == 4 && m_st != 4) m_sh = (m_st == 2);
            m_svc   = cpu_reset ? 5'd0 : taken;
            m_pend  = cpu_reset ? 5'd0 : ((m_pend & ~taken) | (quiet ? 5'd0 : arr));
            m_flush = evt_flush && (m_st == 1 || m_st == 2);
            m_err   = m_err | (quiet & act);
            m_cnt   = !run ? 0 : (done ? m_cnt : m_cnt + 1);
            m_st    = nst;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    // ---------------- main ----------------
    initial begin
        logic [4:0] seen [0:5];
        int smi_cnt;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        tick();
        // R1 reset state
        chk("R1 state", pstate_o, 1);
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 l2_clk_en", l2_clk_en, 1);
        chk("R1 strobes", {svc_vec(), svc_flush}, 0);
        chk("R1 err", illegal_err, 0);
        rst_n = 1'b1;
        tick();

        // R2 halt entry, R3 flush in halt
        halt_stb = 1; tick(); halt_stb = 0;
        chk("R2 halt entry", pstate_o, 2);
        chk("R12 core clk in halt", core_clk_en, 1);
        evt_flush = 1; tick(); evt_flush = 0;
        chk("R3 flush served in halt", svc_flush, 1);
        chk("R3 state kept", pstate_o, 2);
        evt_intr = 1; tick(); evt_intr = 0;
        chk("R2 wake to run", pstate_o, 1);
        chk("R6 no strobe yet", svc_vec(), 0);
        tick();
        chk("R5 intr strobe", svc_intr, 1);

        // R4 grant from run, events latched
        stop_req_n = 0; tick();
        chk("R4 grant entry", pstate_o, 3);
        chk("R12 core clk gated", core_clk_en, 0);
        chk("R11 l2 on in grant", l2_clk_en, 1);
        evt_flush = 1; tick(); evt_flush = 0;
        chk("R3 flush ignored in grant", svc_flush, 0);
        evt_smi = 1; tick(); tick(); evt_smi = 0;
        evt_nmi = 1; tick(); evt_nmi = 0;
        evt_smi = 1; evt_binit = 1; tick(); evt_smi = 0; evt_binit = 0;
        chk("R5 no strobe in grant", svc_vec(), 0);
        stop_req_n = 1; tick();
        chk("R4 back to run", pstate_o, 1);
        smi_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            seen[i] = svc_vec();
            if (svc_smi) smi_cnt++;
            chk("R3 no late flush", svc_flush, 0);
        end
        chk("R6 first binit", seen[0], 5'b00001);
        chk("R6 then smi", seen[1], 5'b00010);
        chk("R6 then nmi", seen[2], 5'b01000);
        chk("R6 then quiet", seen[3], 5'b00000);
        chk("R5 smi once", smi_cnt, 1);

        // R8 sleep ignored in run and halt
        sleep_req_n = 0; tick(); tick();
        chk("R8 sleep ignored run", pstate_o, 1);
        halt_stb = 1; tick(); halt_stb = 0; tick();
        chk("R8 sleep ignored halt", pstate_o, 2);
        sleep_req_n = 1;

        // R7 snoop detours, R4 origin
        stop_req_n = 0; tick();
        chk("R4 grant from halt", pstate_o, 3);
        snoop_start = 1; tick(); snoop_start = 0;
        chk("R7 snoop from grant", pstate_o, 4);
        tick();
        chk("R7 snoop held", pstate_o, 4);
        snoop_done = 1; tick(); snoop_done = 0;
        chk("R7 return to grant", pstate_o, 3);
        stop_req_n = 1; snoop_start = 1; tick(); snoop_start = 0;
        chk("R4 release beats snoop, to halt", pstate_o, 2);
        snoop_start = 1; tick(); snoop_start = 0;
        chk("R7 snoop from halt", pstate_o, 4);
        snoop_done = 1; tick(); snoop_done = 0;
        chk("R7 return to halt", pstate_o, 2);
        evt_init = 1; tick(); evt_init = 0; tick();
        chk("R5 init strobe", svc_init, 1);

        // R8 / R9 / R11 / R12 sleep and deep
        stop_req_n = 0; tick();
        sleep_req_n = 0; tick();
        chk("R8 sleep entry", pstate_o, 5);
        chk("R12 core gated sleep", core_clk_en, 0);
        cfg_gate_en = 0; #1;
        chk("R12 strap off", core_clk_en, 1);
        cfg_gate_en = 1;
        bclk_ok = 0; tick();
        chk("R9 deep entry", pstate_o, 6);
        chk("R11 l2 off", l2_clk_en, 0);
        chk("R12 core gated deep", core_clk_en, 0);
        tick(); tick();
        bclk_ok = 1;
        for (int i = 0; i < 5; i++) tick();
        bclk_ok = 0; tick();
        chk("R9 still deep", pstate_o, 6);
        bclk_ok = 1;
        for (int i = 0; i < SETTLE - 1; i++) tick();
        chk("R9 wait not over", pstate_o, 6);
        tick();
        chk("R9 back in sleep", pstate_o, 5);
        chk("R11 l2 restored", l2_clk_en, 1);
        chk("R13 legal sleep no err", illegal_err, 0);
        sleep_req_n = 1; tick();
        chk("R8 sleep release", pstate_o, 3);
        stop_req_n = 1; tick();
        chk("R4 origin run", pstate_o, 1);

        // R10 core reset
        stop_req_n = 0; tick();
        evt_smi = 1; tick(); evt_smi = 0;
        cpu_reset = 1; tick(); cpu_reset = 0;
        chk("R10 grant kept", pstate_o, 3);
        chk("R10 core_init", core_init, 1);
        tick();
        chk("R10 core_init pulse", core_init, 0);
        stop_req_n = 1; tick();
        smi_cnt = 0;
        for (int i = 0; i < 4; i++) begin tick(); if (svc_smi) smi_cnt++; end
        chk("R10 held cleared", smi_cnt, 0);
        stop_req_n = 0; tick(); sleep_req_n = 0; tick();
        cpu_reset = 1; stop_req_n = 1; sleep_req_n = 1; tick(); cpu_reset = 0;
        chk("R10 sleep to run", pstate_o, 1);
        stop_req_n = 0; tick(); sleep_req_n = 0; tick(); bclk_ok = 0; tick();
        chk("R10 deep reached", pstate_o, 6);
        cpu_reset = 1; stop_req_n = 1; sleep_req_n = 1; bclk_ok = 1; tick(); cpu_reset = 0;
        chk("R10 deep to run", pstate_o, 1);

        // R13 illegal activity
        stop_req_n = 0; tick(); sleep_req_n = 0; tick();
        snoop_start = 1; tick(); snoop_start = 0;
        chk("R13 err set", illegal_err, 1);
        chk("R13 state kept", pstate_o, 5);
        sleep_req_n = 1; tick(); stop_req_n = 1; tick(); tick();
        chk("R13 err sticky", illegal_err, 1);
        por();
        chk("R13 err cleared by por", illegal_err, 0);

        // random phase against model
        m_st = 1; m_cnt = 0; m_gh = 0; m_sh = 0; m_flush = 0; m_err = 0;
        m_pend = 0; m_svc = 0;
        rand_on = 1'b1;
        for (int i = 0; i < N_RAND; i++) begin
            halt_stb    = ($urandom_range(7) == 0);
            if ($urandom_range(15) == 0) stop_req_n = ~stop_req_n;
            if ($urandom_range(7) == 0)  sleep_req_n = ~sleep_req_n;
            if ($urandom_range(9) == 0)  bclk_ok = ~bclk_ok;
            snoop_start = ($urandom_range(9) == 0);
            snoop_done  = ($urandom_range(5) == 0);
            evt_binit   = ($urandom_range(15) == 0);
            evt_smi     = ($urandom_range(15) == 0);
            evt_init    = ($urandom_range(15) == 0);
            evt_nmi     = ($urandom_range(15) == 0);
            evt_intr    = ($urandom_range(15) == 0);
            evt_flush   = ($urandom_range(15) == 0);
            cpu_reset   = ($urandom_range(63) == 0);
            tick();
            chk("R4 R7 R8 R9 random state", pstate_o, m_st);
            chk("R5 R6 random strobes", svc_vec(), m_svc);
            chk("R3 random flush", svc_flush, m_flush);
            chk("R13 random err", illegal_err, m_err);
            chk("R11 random l2", l2_clk_en, (m_st != 6));
            chk("R12 random core", core_clk_en, !(m_st == 3 || m_st == 5 || m_st == 6));
        end
        summary();
    end
endmodule